// File: doc/BRIEF.md
# Complemented Command Frame Decoder

This block sits behind a byte-wide serial receiver and turns its byte stream into channel commands. The receiver presents one byte per cycle with a valid strobe. The decoder groups the bytes into four-byte frames. Byte 0 of a frame carries a command code and byte 1 must be its bitwise inverse. Bytes 2 and 3 complete the frame, and their contents are not used.

When a frame passes the inverse check and its code is one of four known values, the decoder issues a one-cycle write request to a downstream command latch. The request carries a channel number and a two-bit state. A frame that fails the inverse check is dropped and counted in a saturating reject counter. A frame with a known-good inverse but an unknown code is dropped silently.

If the byte stream stalls in the middle of a frame for too long, the partial frame is abandoned. The next byte then starts a new frame. The stall limit is measured in clock cycles and set by a parameter. The serial source is expected to run at 9600 baud with 8-bit asynchronous characters, so in normal traffic the bytes are far apart in clock cycles.

Top module: `cmd_frame_decoder`

## Requirements
- R1: While reset is held and right after it is released, `wr_valid` is 0, `wr_chan` is 0, `wr_state` is 0 and `reject_count` is 0.
- R2: A frame is four bytes, each marked by `rx_valid`. A frame is accepted only when byte 1 equals byte 0 XOR 0xFF. The write request appears in the clock cycle after the cycle in which byte 3 is presented.
- R3: The code in byte 0 sets the outputs. Code 0x31 gives channel 1 and state 2. Code 0x30 gives channel 2 and state 1. Code 0x11 gives channel 3 and state 2. Code 0x10 gives channel 4 and state 1. `wr_chan` carries the channel number minus one, so channels 1..4 are driven as 0..3.
- R4: `wr_valid` is high for exactly one cycle per accepted frame. `wr_chan` and `wr_state` keep their last written values between requests.
- R5: A frame with a correct inverse byte but any other code gives no write request and leaves `reject_count` unchanged.
- R6: The byte position returns to 0 after every fourth byte, whether the frame was accepted or not. The contents of bytes 2 and 3 have no effect.
- R7: Each frame whose inverse check fails adds one to `reject_count`, visible one cycle after byte 3. The count stops at 2^CNT_W-1.
- R8: Inside a frame, if TIMEOUT_CYC consecutive cycles pass without `rx_valid`, the partial frame is discarded without counting it, and the next byte is treated as byte 0. A gap of TIMEOUT_CYC-1 idle cycles keeps the frame intact.
- R9: Bytes presented on every cycle with no idle gaps, across frame boundaries, are decoded the same as spaced bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe from the serial receiver |
| rx_data | input | 8 | Received byte |
| wr_valid | output | 1 | One-cycle write request to the command latch |
| wr_chan | output | 2 | Channel number minus one |
| wr_state | output | 2 | Command state for the channel |
| reject_count | output | CNT_W | Saturating count of frames that failed the inverse check |

## Verification
The bench builds the decoder with CNT_W = 3 and TIMEOUT_CYC = 6. The 3-bit counter saturates after seven bad frames, so the bench can drive it past its ceiling in a few dozen cycles. The short timeout lets the bench test the exact stall boundary: a gap of five idle cycles keeps the frame, and a gap of six drops it. The bench also sends each code both with idle gaps between bytes and as a continuous back-to-back stream.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  typedef struct packed {
    logic       hit;
    logic [1:0] chan;
    logic [1:0] state;
  } cfd_cmd_t;

  localparam logic [7:0] INV_MASK = 8'hFF;

  function automatic cfd_cmd_t cfd_lookup_code(input logic [7:0] code);
    cfd_cmd_t r;
    r = '0;
    unique case (code)
      8'h31:   begin r.hit = 1'b1; r.chan = 2'd0; r.state = 2'd2; end
      8'h30:   begin r.hit = 1'b1; r.chan = 2'd1; r.state = 2'd1; end
      8'h11:   begin r.hit = 1'b1; r.chan = 2'd2; r.state = 2'd2; end
      8'h10:   begin r.hit = 1'b1; r.chan = 2'd3; r.state = 2'd1; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfd_assembler.sv
module cfd_assembler #(
  parameter int TIMEOUT_CYC = 16,
  parameter int FRAME_LEN   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       frame_done,
  output logic [7:0] code,
  output logic [7:0] code_inv
);
  localparam int IDX_W  = $clog2(FRAME_LEN);
  localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(TIMEOUT_CYC - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [7:0]        code_q, inv_q;
  logic              code_en, inv_en;

  // next-state
  always_comb begin
    idx_d  = idx_q;
    idle_d = idle_q;
    if (rx_valid) begin
      idx_d  = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      idle_d = '0;
    end else if (idx_q != '0) begin
      if (idle_q == IDLE_LIM) begin
        idx_d  = '0;
        idle_d = '0;
      end else begin
        idle_d = idle_q + 1'b1;
      end
    end
  end

  assign code_en    = rx_valid && (idx_q == IDX_W'(0));
  assign inv_en     = rx_valid && (idx_q == IDX_W'(1));
  assign frame_done = rx_valid && (idx_q == LAST_IDX);
  assign code       = code_q;
  assign code_inv   = inv_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      idle_q <= '0;
    end else begin
      idx_q  <= idx_d;
      idle_q <= idle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      inv_q  <= '0;
    end else begin
      if (code_en) code_q <= rx_data;
      if (inv_en)  inv_q  <= rx_data;
    end
  end

  // R6 / R9: every byte moves the position by one, wrapping after the last
  a_r6_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (idx_q == (($past(idx_q) == LAST_IDX) ? '0 : $past(idx_q) + 1'b1)));

  // R8: a stall of the full limit always returns to byte 0
  a_r8_stall_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && idx_q != '0 && idle_q == IDLE_LIM) |=> (idx_q == '0));

endmodule

// File: rtl/cfd_reject_counter.sv
module cfd_reject_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = inc && (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R7: saturates at the ceiling
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R7: only ever steps by one
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             wr_valid,
  output logic [1:0]       wr_chan,
  output logic [1:0]       wr_state,
  output logic [CNT_W-1:0] reject_count
);
  import cfd_pkg::*;

  logic       frame_done;
  logic [7:0] code, code_inv;
  cfd_cmd_t   cmd;
  logic       inv_ok, accept, reject;

  logic       wv_q, wv_d;
  logic [1:0] ch_q, st_q;

  cfd_assembler #(.TIMEOUT_CYC(TIMEOUT_CYC), .FRAME_LEN(4)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .frame_done (frame_done),
    .code       (code),
    .code_inv   (code_inv)
  );

  assign cmd    = cfd_lookup_code(code);
  assign inv_ok = ((code ^ code_inv) == INV_MASK);
  assign accept = frame_done && inv_ok && cmd.hit;
  assign reject = frame_done && !inv_ok;

  cfd_reject_counter #(.CNT_W(CNT_W)) u_rej (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (reject),
    .count (reject_count)
  );

  always_comb wv_d = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
      ch_q <= '0;
      st_q <= '0;
    end else begin
      wv_q <= wv_d;
      if (accept) begin
        ch_q <= cmd.chan;
        st_q <= cmd.state;
      end
    end
  end

  assign wr_valid = wv_q;
  assign wr_chan  = ch_q;
  assign wr_state = st_q;

  // R4: request lasts one cycle
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R2: a request follows a cycle carrying a byte
  a_r2_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(rx_valid));

  // R4: channel and state hold when no request is issued
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> ($stable(wr_chan) && $stable(wr_state)));

endmodule

// File: tb/cmd_frame_decoder_bench.sv
module cmd_frame_decoder_bench;
  localparam int CW  = 3;
  localparam int TO  = 6;
  localparam int MAXC = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_valid;
  logic [7:0]    rx_data;
  logic          wr_valid;
  logic [1:0]    wr_chan, wr_state;
  logic [CW-1:0] reject_count;

  int checks = 0, fails = 0, pulses = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_idx = 0, m_gap = 0, m_b0 = 0, m_b1 = 0;
  int e_valid = 0, e_chan = 0, e_state = 0, e_rej = 0;

  always #4 clk = ~clk;

  cmd_frame_decoder #(.CNT_W(CW), .TIMEOUT_CYC(TO)) u_cmd_frame_decoder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_state(wr_state),
    .reject_count(reject_count));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: applies requirements to each sampled cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_gap = 0; e_valid = 0; e_chan = 0; e_state = 0; e_rej = 0;
    end else begin
      e_valid = 0;
      if (rx_valid) begin
        if (m_idx == 0) m_b0 = rx_data;
        if (m_idx == 1) m_b1 = rx_data;
        if (m_idx == 3) begin
          if ((m_b0 ^ m_b1) != 255) begin
            if (e_rej < MAXC) e_rej++;
          end else begin
            case (m_b0)
              'h31: begin e_valid = 1; e_chan = 0; e_state = 2; end
              'h30: begin e_valid = 1; e_chan = 1; e_state = 1; end
              'h11: begin e_valid = 1; e_chan = 2; e_state = 2; end
              'h10: begin e_valid = 1; e_chan = 3; e_state = 1; end
              default: ;
            endcase
          end
        end
        m_idx = (m_idx + 1) % 4;
        m_gap = 0;
      end else if (m_idx != 0) begin
        m_gap++;
        if (m_gap >= TO) begin m_idx = 0; m_gap = 0; end
      end
    end
  end

  // per-cycle compare, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R2/R4 wr_valid", wr_valid, e_valid);
      chk("R3 wr_chan", wr_chan, e_chan);
      chk("R3 wr_state", wr_state, e_state);
      chk("R7 reject_count", reject_count, e_rej);
      if (wr_valid) pulses++;
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b0; rx_data = 8'hA5;
    end
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] inv, input int gap);
    put(c);   idle(gap);
    put(inv); idle(gap);
    put(8'h5A); idle(gap);
    put(8'hC3); idle(gap);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 20000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset wr_valid", wr_valid, 0);
    chk("R1 reset reject_count", reject_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release wr_chan", wr_chan, 0);
    chk("R1 after release wr_state", wr_state, 0);

    // R3: every code, spaced bytes
    p0 = pulses;
    frame(8'h31, 8'hCE, 2); frame(8'h30, 8'hCF, 1);
    frame(8'h11, 8'hEE, 3); frame(8'h10, 8'hEF, 0);
    idle(3);
    chk("R3 spaced pulses", pulses - p0, 4);

    // R9: continuous stream, reverse order
    p0 = pulses;
    frame(8'h10, 8'hEF, 0); frame(8'h11, 8'hEE, 0);
    frame(8'h30, 8'hCF, 0); frame(8'h31, 8'hCE, 0);
    idle(3);
    chk("R9 back-to-back pulses", pulses - p0, 4);
    chk("R4 hold chan", wr_chan, 0);

    // R5: unknown code with good inverse
    p0 = pulses;
    frame(8'h55, 8'hAA, 1); frame(8'h00, 8'hFF, 0);
    idle(3);
    chk("R5 unknown no write", pulses - p0, 0);
    chk("R5 unknown no reject", reject_count, 0);

    // R6: bad inverse then good frame realigns
    p0 = pulses;
    frame(8'h31, 8'h31, 0); frame(8'h30, 8'hCF, 0);
    idle(3);
    chk("R6 realign after reject", pulses - p0, 1);
    chk("R7 one reject", reject_count, 1);

    // R7: saturate
    for (int k = 0; k < 9; k++) frame(8'h11, 8'h00, 0);
    idle(3);
    chk("R7 saturated", reject_count, MAXC);

    // R8: stall of TO drops partial frame
    p0 = pulses;
    put(8'h30); put(8'hCF); idle(TO);
    frame(8'h11, 8'hEE, 0);
    idle(3);
    chk("R8 stall drop", pulses - p0, 1);
    chk("R8 stall state", wr_state, 2);

    // R8: gap of TO-1 keeps frame
    p0 = pulses;
    put(8'h10); idle(TO - 1); put(8'hEF); idle(TO - 1); put(8'h01); put(8'h02);
    idle(3);
    chk("R8 gap kept", pulses - p0, 1);
    chk("R8 gap chan", wr_chan, 3);

    finish_run();
  end
endmodule